// File: doc/BRIEF.md
# Queued Rectangle Fill Engine

This block paints solid rectangles into a 16-bit-per-pixel frame store. The host does not program start and size registers directly. It pushes 32-bit command words into a 512-entry queue. Each word carries an 8-bit opcode in its top byte and an argument below it.

Parameter commands set the destination start address, the width and height, and the fill colour. A fill command then takes a snapshot of those values and streams one pixel per cycle out of a plain memory write port. While a fill runs, the engine takes nothing from the queue. The host can therefore keep queuing work during a fill, up to the queue depth.

The host sees a small register window:

| Index | Access | Purpose |
|-------|--------|---------|
| 0 | write | Upper half of a command word |
| 1 | write | Lower half of a command word, which pushes the word |
| 2 | read | Queue level |
| 3 | read | Status |
| 4 | read/write | Interrupt mask |
| 5 | read, write-1-to-clear | Completion flag |

Top module: `rectfill_engine`

## Requirements
- R1: A write to index 0 holds the upper 16 bits of a command. A write to index 1 pushes {held upper half, written lower half} into the queue. Index 2 reads the number of words waiting, from 0 up to 512.
- R2: A push while 512 words are waiting is dropped. It sets status bit 2, which stays set until reset.
- R3: The opcode is word bits 31:24 and the argument is bits 23:0. Opcode 0x0C sets the 24-bit destination start address to {argument bits 23:1, 0}, so the address is always even.
- R4: Opcode 0x0E sets the width minus one and opcode 0x0F sets the height minus one, each from argument bits 9:0. Opcode 0x0B sets the fill colour from argument bits 15:0.
- R5: Opcode 0x23 writes (width)×(height) pixels, one per cycle, rows top to bottom and pixels left to right. The line stride is width×2, so the byte addresses are start+2k, wrapping at 24 bits. Every pixel carries the fill colour.
- R6: While a fill runs, no word leaves the queue, so the level does not drop. A colour command queued during a fill does not change the pixels of that fill.
- R7: Status bit 1 reads 1 while a fill runs. Status bit 0 reads 1 in a cycle when a pixel is written.
- R8: Argument bit 1 of the fill command sets completion flag bit 0 (index 5) when the fill ends. Writing 1 to that bit clears it. A fill without the request leaves the flag at 0. The irq output equals flag AND NOT mask.
- R9: Mask bit 0 (index 4) resets to 0 and reads back what was written. While it is 1, irq stays low.
- R10: Argument bit 0 of the fill command marks end of stream. Status bit 3 is set when such a fill ends and cleared when the next fill starts.
- R11: Words with any other opcode are removed from the queue and change no parameter.
- R12: After reset, the level, status, mask and flag read 0, and mem_we and irq are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_waddr | input | 3 | Register index written |
| host_wdata | input | 16 | Register write data |
| host_raddr | input | 3 | Register index read |
| host_rdata | output | 16 | Register read data (combinational) |
| mem_we | output | 1 | Pixel write enable |
| mem_addr | output | 24 | Pixel byte address |
| mem_wdata | output | 16 | Pixel colour |
| irq | output | 1 | Completion interrupt |

## Verification
The bench aims at these corner cases:

- An odd start address, which must come out even. A design that kept bit 0 would write misaligned pixels.
- A fill that crosses the top of the address space, where a wrong carry would scatter pixels.
- Single-pixel and single-column rectangles, which catch off-by-one errors in the minus-one counts.
- A queue filled to exactly 512 behind a long fill, plus one extra word. A design that popped during the fill would show a falling level and stray colours. A design without the full check would corrupt a queued word.
- Interrupt mask, flag clear and end-of-stream ordering, plus junk opcodes. A decoder that did not ignore junk opcodes would change the next rectangle's start address or colour.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 32;

  localparam logic [7:0] OP_DST   = 8'h0C;
  localparam logic [7:0] OP_HCNT  = 8'h0E;
  localparam logic [7:0] OP_VCNT  = 8'h0F;
  localparam logic [7:0] OP_COLOR = 8'h0B;
  localparam logic [7:0] OP_GO    = 8'h23;

  localparam logic [2:0] REG_CMD_HI = 3'd0;
  localparam logic [2:0] REG_CMD_LO = 3'd1;
  localparam logic [2:0] REG_LEVEL  = 3'd2;
  localparam logic [2:0] REG_STATUS = 3'd3;
  localparam logic [2:0] REG_MASK   = 3'd4;
  localparam logic [2:0] REG_FLAG   = 3'd5;

  typedef enum logic {ST_IDLE, ST_FILL} fill_state_e;

  // Destination addresses are halfword aligned.
  function automatic logic [ADDR_W-1:0] align_even(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:1], 1'b0};
  endfunction

  // One 16-bit pixel per step; wraps at the top of the address space.
  function automatic logic [ADDR_W-1:0] next_pixel(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(2);
  endfunction
endpackage

// File: rtl/rfe_cmd_fifo.sv
module rfe_cmd_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;

  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);
  assign level = cnt;
  assign dout  = store[rp];

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + LW'(1);
        2'b01:   cnt <= cnt - LW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rfe_host_regs.sv
module rfe_host_regs
  import rfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [15:0]       wr_data,
  input  logic              q_full,
  input  logic              done_irq,
  output logic              push,
  output logic [WORD_W-1:0] push_word,
  output logic              irq_mask,
  output logic              done_flag,
  output logic              q_ovf
);
  logic [15:0] hi_q;

  wire lo_wr    = wr_en && (wr_sel == REG_CMD_LO);
  wire flag_clr = wr_en && (wr_sel == REG_FLAG) && wr_data[0];

  assign push      = lo_wr && !q_full;
  assign push_word = {hi_q, wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= '0;
      irq_mask  <= 1'b0;
      done_flag <= 1'b0;
      q_ovf     <= 1'b0;
    end else begin
      if (wr_en && wr_sel == REG_CMD_HI) hi_q <= wr_data;
      if (wr_en && wr_sel == REG_MASK) irq_mask <= wr_data[0];
      if (lo_wr && q_full) q_ovf <= 1'b1;
      // A completion in the same cycle as a clear wins.
      if (done_irq) done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rfe_fill_core.sv
module rfe_fill_core
  import rfe_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PIX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [WORD_W-1:0] q_word,
  output logic              q_pop,
  output logic              busy,
  output logic              pix_we,
  output logic [ADDR_W-1:0] pix_addr,
  output logic [PIX_W-1:0]  pix_data,
  output logic              fill_done,
  output logic              done_irq,
  output logic              eos_seen
);
  fill_state_e       state;
  logic [ADDR_W-1:0] dst_q, cur_q;
  logic [CNT_W-1:0]  wm1_q, hm1_q, x_q, y_q;
  logic [PIX_W-1:0]  color_q;
  logic              want_irq_q, want_eos_q;

  wire [7:0]        opcode = q_word[WORD_W-1:WORD_W-8];
  wire [ADDR_W-1:0] arg    = q_word[ADDR_W-1:0];

  assign busy      = (state == ST_FILL);
  assign q_pop     = (state == ST_IDLE) && !q_empty;
  assign pix_we    = busy;
  assign pix_addr  = cur_q;
  assign pix_data  = color_q;
  assign fill_done = busy && (x_q == wm1_q) && (y_q == hm1_q);
  assign done_irq  = fill_done && want_irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      dst_q      <= '0;
      cur_q      <= '0;
      wm1_q      <= '0;
      hm1_q      <= '0;
      x_q        <= '0;
      y_q        <= '0;
      color_q    <= '0;
      want_irq_q <= 1'b0;
      want_eos_q <= 1'b0;
      eos_seen   <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (q_pop) begin
        case (opcode)
          OP_DST:   dst_q   <= align_even(arg);
          OP_HCNT:  wm1_q   <= arg[CNT_W-1:0];
          OP_VCNT:  hm1_q   <= arg[CNT_W-1:0];
          OP_COLOR: color_q <= arg[PIX_W-1:0];
          OP_GO: begin
            state      <= ST_FILL;
            cur_q      <= dst_q;
            x_q        <= '0;
            y_q        <= '0;
            want_irq_q <= arg[1];
            want_eos_q <= arg[0];
            eos_seen   <= 1'b0;
          end
          default: ;
        endcase
      end
    end else begin
      // Stride equals width*2, so rows are contiguous and the address just steps.
      cur_q <= next_pixel(cur_q);
      if (x_q == wm1_q) begin
        x_q <= '0;
        if (y_q == hm1_q) begin
          state    <= ST_IDLE;
          eos_seen <= want_eos_q;
        end else begin
          y_q <= y_q + CNT_W'(1);
        end
      end else begin
        x_q <= x_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rectfill_engine.sv
module rectfill_engine
  import rfe_pkg::*;
#(
  parameter int QDEPTH = 512,
  parameter int CNT_W  = 10,
  parameter int PIX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [2:0]        host_waddr,
  input  logic [15:0]       host_wdata,
  input  logic [2:0]        host_raddr,
  output logic [15:0]       host_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  output logic              irq
);
  localparam int LW = $clog2(QDEPTH + 1);

  logic              q_push, q_pop, q_empty, q_full;
  logic [WORD_W-1:0] q_din, q_dout;
  logic [LW-1:0]     q_level;
  logic              eng_busy, fill_done, done_irq, eos_seen;
  logic              irq_mask, done_flag, q_ovf;

  rfe_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(host_we), .wr_sel(host_waddr),
    .wr_data(host_wdata), .q_full(q_full), .done_irq(done_irq),
    .push(q_push), .push_word(q_din), .irq_mask(irq_mask),
    .done_flag(done_flag), .q_ovf(q_ovf)
  );

  rfe_cmd_fifo #(.DEPTH(QDEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din), .pop(q_pop),
    .dout(q_dout), .empty(q_empty), .full(q_full), .level(q_level)
  );

  rfe_fill_core #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_core (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_word(q_dout),
    .q_pop(q_pop), .busy(eng_busy), .pix_we(mem_we), .pix_addr(mem_addr),
    .pix_data(mem_wdata), .fill_done(fill_done), .done_irq(done_irq),
    .eos_seen(eos_seen)
  );

  assign irq = done_flag && !irq_mask;

  always_comb begin
    case (host_raddr)
      REG_LEVEL:  host_rdata = 16'(q_level);
      REG_STATUS: host_rdata = {12'd0, eos_seen, q_ovf, eng_busy, mem_we};
      REG_MASK:   host_rdata = {15'd0, irq_mask};
      REG_FLAG:   host_rdata = {15'd0, done_flag};
      default:    host_rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
  parameter int QDEPTH = 512
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        mem_we,
  input logic [23:0]                 mem_addr,
  input logic                        busy,
  input logic                        pop,
  input logic [$clog2(QDEPTH+1)-1:0] level,
  input logic                        irq,
  input logic                        mask,
  input logic                        flag,
  input logic                        ovf
);
  p_even_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_addr[0]);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == 24'($past(mem_addr) + 24'd2)));

  p_no_pop_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pop);

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(QDEPTH+1))'(QDEPTH));

  p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

bind rectfill_engine rfe_checker #(.QDEPTH(QDEPTH)) u_rfe_checker (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .busy(eng_busy), .pop(q_pop), .level(q_level), .irq(irq),
  .mask(irq_mask), .flag(done_flag), .ovf(q_ovf)
);

// File: tb/test_rectfill_engine.sv
`timescale 1ns/1ps
module test_rectfill_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_waddr = '0;
  logic [15:0] host_wdata = '0;
  logic [2:0]  host_raddr = '0;
  logic [15:0] host_rdata;
  logic        mem_we;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  int          pix_n, bad_color, bad_step;
  logic [23:0] first_a, last_a, prev_a;
  logic [15:0] exp_color;

  always #4 clk = ~clk;

  rectfill_engine i_rectfill_engine (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
  );

  // Pixel monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      pix_n = pix_n + 1;
      if (pix_n == 1) first_a = mem_addr;
      else if (mem_addr != 24'(prev_a + 24'd2)) bad_step = bad_step + 1;
      if (mem_wdata != exp_color) bad_color = bad_color + 1;
      prev_a = mem_addr;
      last_a = mem_addr;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic push_cmd(input logic [7:0] op, input logic [23:0] arg);
    wr_reg(3'd0, {op, arg[23:16]});
    wr_reg(3'd1, arg[15:0]);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    host_raddr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic clear_mon(input logic [15:0] c);
    pix_n = 0; bad_color = 0; bad_step = 0; exp_color = c;
    first_a = '0; last_a = '0; prev_a = '0;
  endtask

  task automatic wait_idle();
    logic [15:0] st, lv;
    int n = 0;
    forever begin
      @(negedge clk);
      rd_reg(3'd3, st);
      rd_reg(3'd2, lv);
      if (!st[1] && lv == 0) break;
      n++;
      if (n > 20000) begin
        check(1'b0, "wait_idle timeout", st, 0);
        break;
      end
    end
    @(negedge clk);
  endtask

  // {start address, width-1, height-1, colour}
  localparam logic [59:0] CASES [5] = '{
    {24'h000100, 10'd3, 10'd1, 16'hF800},
    {24'h000123, 10'd0, 10'd0, 16'h07E0},
    {24'h001000, 10'd9, 10'd0, 16'h001F},
    {24'hFFFFFC, 10'd1, 10'd1, 16'hABCD},
    {24'h000200, 10'd0, 10'd4, 16'h1234}
  };

  initial begin
    #1_500_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    clear_mon(16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd_reg(3'd2, d); check(d == 0, "R12 level", d, 0);
    rd_reg(3'd3, d); check(d == 0, "R12 status", d, 0);
    rd_reg(3'd4, d); check(d == 0, "R12 mask", d, 0);
    rd_reg(3'd5, d); check(d == 0, "R12 flag", d, 0);
    check(!mem_we && !irq, "R12 mem_we/irq", {mem_we, irq}, 0);

    // Table of rectangles: R3 R4 R5
    for (int i = 0; i < 5; i++) begin
      logic [23:0] sa, ea, la;
      logic [9:0]  wm, hm;
      logic [15:0] c;
      int          n;
      {sa, wm, hm, c} = CASES[i];
      ea = {sa[23:1], 1'b0};
      n  = (int'(wm) + 1) * (int'(hm) + 1);
      la = 24'(ea + 24'(2 * (n - 1)));
      clear_mon(c);
      push_cmd(8'h0C, sa);
      push_cmd(8'h0E, {14'd0, wm});
      push_cmd(8'h0F, {14'd0, hm});
      push_cmd(8'h0B, {8'd0, c});
      push_cmd(8'h23, 24'd0);
      wait_idle();
      check(pix_n == n, $sformatf("R5 pixel count case %0d", i), pix_n, n);
      check(first_a == ea, $sformatf("R3 first address case %0d", i), first_a, ea);
      check(last_a == la, $sformatf("R5 last address case %0d", i), last_a, la);
      check(bad_color == 0, $sformatf("R4 colour case %0d", i), bad_color, 0);
      check(bad_step == 0, $sformatf("R5 address step case %0d", i), bad_step, 0);
    end

    // Long fill with a queue filled behind it: R1 R2 R6 R7 R11
    clear_mon(16'h0F0F);
    push_cmd(8'h0C, 24'h004000);
    push_cmd(8'h0E, 24'd1023);
    push_cmd(8'h0F, 24'd3);
    push_cmd(8'h0B, 24'h000F0F);
    push_cmd(8'h23, 24'd0);
    push_cmd(8'h0E, 24'd1);
    push_cmd(8'h0F, 24'd0);
    push_cmd(8'h0B, 24'h005555);
    rd_reg(3'd2, d); check(d == 3, "R1 level during fill", d, 3);
    rd_reg(3'd3, d); check(d[1:0] == 2'b11, "R7 busy and write bits", d[1:0], 3);
    for (int k = 0; k < 509; k++) begin
      logic [7:0] op;
      op = (k % 3 == 0) ? 8'h0D : ((k % 3 == 1) ? 8'h22 : 8'hFF);
      push_cmd(op, 24'hFFFFFF);
    end
    rd_reg(3'd2, d); check(d == 512, "R1 level at full", d, 512);
    rd_reg(3'd3, d); check(d[2] == 1'b0, "R2 no overflow yet", d[2], 0);
    push_cmd(8'h0C, 24'h000000);
    rd_reg(3'd3, d); check(d[2] == 1'b1, "R2 overflow set", d[2], 1);
    rd_reg(3'd2, d); check(d == 512, "R6 level holds while busy", d, 512);
    wait_idle();
    check(pix_n == 4096, "R5 long fill count", pix_n, 4096);
    check(bad_color == 0, "R6 colour unchanged by queued command", bad_color, 0);
    rd_reg(3'd3, d); check(d[2] == 1'b1, "R2 overflow sticky", d[2], 1);

    // Junk opcodes must not touch the address, colour or size: R11
    clear_mon(16'h5555);
    push_cmd(8'h23, 24'd0);
    wait_idle();
    check(pix_n == 2, "R11 size kept", pix_n, 2);
    check(first_a == 24'h004000, "R11 address kept", first_a, 24'h004000);
    check(bad_color == 0, "R11 colour kept", bad_color, 0);

    // Interrupt, mask and end of stream: R8 R9 R10
    clear_mon(16'h5555);
    push_cmd(8'h23, 24'd3);
    wait_idle();
    rd_reg(3'd5, d); check(d == 1, "R8 flag set", d, 1);
    check(irq == 1'b1, "R8 irq raised", irq, 1);
    rd_reg(3'd3, d); check(d[3] == 1'b1, "R10 end of stream set", d[3], 1);
    wr_reg(3'd4, 16'd1);
    rd_reg(3'd4, d); check(d == 1, "R9 mask readback", d, 1);
    check(irq == 1'b0, "R9 irq masked", irq, 0);
    wr_reg(3'd4, 16'd0);
    check(irq == 1'b1, "R9 irq unmasked", irq, 1);
    wr_reg(3'd5, 16'd1);
    rd_reg(3'd5, d); check(d == 0, "R8 flag cleared", d, 0);
    check(irq == 1'b0, "R8 irq cleared", irq, 0);
    push_cmd(8'h23, 24'd0);
    wait_idle();
    rd_reg(3'd5, d); check(d == 0, "R8 no request no flag", d, 0);
    rd_reg(3'd3, d); check(d[3] == 1'b0, "R10 end of stream cleared", d[3], 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule